// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block generates the time-multiplexed drive codes for a passive LCD panel. For every common line and every segment line it emits a two-bit level code each cycle. An analog stage outside the block turns each code into a voltage. It scans the commons one time slot at a time. For each segment it picks the display bit that belongs to the active common, and it reverses drive polarity on every frame so the panel sees no net DC.

The block takes an already-latched display bit vector and several mode inputs. A duty select chooses three or four commons. A bias select chooses half or third bias. The other inputs are a segment-blank control, a power-save control and a base-oscillator enable. Slot length is a parameterized number of enable pulses. One output pin changes role with the duty mode: it is the fourth common in quarter duty and the last segment in third duty.

Level codes used everywhere:
- 0 is ground.
- 1 is the lower middle level: one third of the supply, or half the supply under half bias.
- 2 is two thirds of the supply.
- 3 is the full supply.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While `rst` is high every output is code 0. The first slot after reset drives common 1 in a positive frame.
- R2: A slot lasts `DIV_RATIO` cycles with `osc_en` high; cycles with `osc_en` low do not advance the scan. Commons are scanned in order 1, 2, 3 (then 4 in quarter duty), and polarity inverts after the last common of each frame.
- R3: The selected common is code 3 in a positive frame and code 0 in a negative frame. A non-selected common is code 1, except under third bias in a negative frame, where it is code 2.
- R4: A segment whose bit is 1 is code 0 in a positive frame and code 3 in a negative frame. A segment whose bit is 0 is code 1 under half bias. Under third bias it is code 2 in a positive frame and code 1 in a negative frame.
- R5: With `quarter_duty`=0, segment k (from 0) in slot i (from 0) shows `disp_bits[3k+i]`. The shared pin acts as segment `SEG_PINS` and shows bit `3*SEG_PINS+i`.
- R6: With `quarter_duty`=1, segment k in slot i shows `disp_bits[4k+i]`, and the shared pin is the fourth common.
- R7: Under half bias (`third_bias`=0) no output ever carries code 2.
- R8: While `seg_blank` is high every segment output, including the shared pin in third duty, takes its OFF level, and the commons keep scanning unchanged.
- R9: While `power_save` is high every output is code 0 and the scan position and polarity are frozen. On release the scan resumes from where it stopped.
- R10: When not in reset or power save, exactly one common (counting the shared pin only in quarter duty) is at an extreme level (0 or 3) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Base oscillator enable pulse |
| disp_bits | input | 4*SEG_PINS | Latched display data |
| quarter_duty | input | 1 | 1 = four commons, 0 = three commons |
| third_bias | input | 1 | 1 = third bias, 0 = half bias |
| seg_blank | input | 1 | Force all segments OFF |
| power_save | input | 1 | Stop drive and freeze the scan |
| com_drive | output | 6 | Level codes of commons 1..3, two bits each, common 1 lowest |
| shared_drive | output | 2 | Level code of the shared common 4 / last segment pin |
| seg_drive | output | 2*SEG_PINS | Level codes of dedicated segments, segment 0 lowest |

## Verification
Two events can land in the same cycle: power-save being raised and the slot boundary that would otherwise advance the scan or wrap the frame. The bench waits until the slot counter sits at its last count with the enable high, and raises power save in exactly that cycle. It then checks two things: the outputs go dark, and after release the scan continues from the slot and polarity held before, not one step later. A bench-side timing model, driven only by the port inputs, gives the expected slot and polarity for every sampled cycle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    // Two-bit drive level codes
    typedef enum logic [1:0] {
        LV_GND  = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_VDD  = 2'd3
    } lvl_e;

    // Per-cycle drive context shared by common and segment mappers
    typedef struct packed {
        logic bias3;   // third bias when set
        logic neg;     // negative frame when set
    } drive_ctx_t;

    function automatic lvl_e com_level(drive_ctx_t ctx, logic sel);
        if (sel)
            return ctx.neg ? LV_GND : LV_VDD;
        return (ctx.bias3 && ctx.neg) ? LV_HIGH : LV_LOW;
    endfunction

    function automatic lvl_e seg_level(drive_ctx_t ctx, logic on);
        if (on)
            return ctx.neg ? LV_VDD : LV_GND;
        if (!ctx.bias3)
            return LV_LOW;
        return ctx.neg ? LV_LOW : LV_HIGH;
    endfunction

    function automatic logic pick3(logic [2:0] grp, logic [1:0] slot);
        case (slot)
            2'd0:    return grp[0];
            2'd1:    return grp[1];
            2'd2:    return grp[2];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
    parameter int DIV_RATIO = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       hold,
    input  logic       duty4,
    output logic [1:0] slot,
    output logic       neg
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt;
    logic [1:0]    last_slot;
    logic          adv;
    logic          wrap;

    always_comb begin
        last_slot = duty4 ? 2'd3 : 2'd2;
        adv       = osc_en && !hold && (cnt == CNT_LAST);
        wrap      = (slot >= last_slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            slot <= 2'd0;
            neg  <= 1'b0;
        end else if (osc_en && !hold) begin
            if (adv) begin
                cnt <= '0;
                if (wrap) begin
                    slot <= 2'd0;
                    neg  <= ~neg;
                end else begin
                    slot <= slot + 2'd1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: in three-common mode the scan never lands on a fourth slot
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !duty4) |=> (slot != 2'd3));

    // R2: the end of a frame inverts polarity
    assert_frame_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && wrap) |=> (neg != $past(neg)));

    // R9: power save freezes scan position and polarity
    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(slot) && $stable(neg)));

endmodule

// File: rtl/lcd_bit_picker.sv
module lcd_bit_picker
    import lcd_seq_pkg::*;
#(
    parameter int SEG_PINS = 50
) (
    input  logic [4*SEG_PINS-1:0] bits,
    input  logic [1:0]            slot,
    input  logic                  duty4,
    output logic [SEG_PINS:0]     seg_on
);
    // SEG_PINS must be at least 3 so the extra third-duty group fits in bits
    for (genvar k = 0; k < SEG_PINS; k++) begin : g_seg
        logic [3:0] quad;
        logic [2:0] trio;
        assign quad      = bits[4*k +: 4];
        assign trio      = bits[3*k +: 3];
        assign seg_on[k] = duty4 ? quad[slot] : pick3(trio, slot);
    end

    // Shared pin: segment only in three-common mode
    logic [2:0] last_trio;
    assign last_trio        = bits[3*SEG_PINS +: 3];
    assign seg_on[SEG_PINS] = duty4 ? 1'b0 : pick3(last_trio, slot);

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int SEG_PINS  = 50,
    parameter int DIV_RATIO = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  osc_en,
    input  logic [4*SEG_PINS-1:0] disp_bits,
    input  logic                  quarter_duty,
    input  logic                  third_bias,
    input  logic                  seg_blank,
    input  logic                  power_save,
    output logic [5:0]            com_drive,
    output logic [1:0]            shared_drive,
    output logic [2*SEG_PINS-1:0] seg_drive
);
    localparam int DEDICATED_COMS = 3;

    logic [1:0]        slot;
    logic              neg;
    logic [SEG_PINS:0] seg_on;
    logic              run;
    drive_ctx_t        ctx;

    lcd_slot_timer #(.DIV_RATIO(DIV_RATIO)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .osc_en (osc_en),
        .hold   (power_save),
        .duty4  (quarter_duty),
        .slot   (slot),
        .neg    (neg)
    );

    lcd_bit_picker #(.SEG_PINS(SEG_PINS)) u_pick (
        .bits   (disp_bits),
        .slot   (slot),
        .duty4  (quarter_duty),
        .seg_on (seg_on)
    );

    always_comb begin
        run       = !rst && !power_save;
        ctx.bias3 = third_bias;
        ctx.neg   = neg;
    end

    for (genvar c = 0; c < DEDICATED_COMS; c++) begin : g_com
        assign com_drive[2*c +: 2] = run ? com_level(ctx, slot == 2'(c)) : LV_GND;
    end

    always_comb begin
        if (!run)
            shared_drive = LV_GND;
        else if (quarter_duty)
            shared_drive = com_level(ctx, slot == 2'd3);
        else
            shared_drive = seg_level(ctx, seg_on[SEG_PINS] && !seg_blank);
    end

    for (genvar k = 0; k < SEG_PINS; k++) begin : g_seg
        assign seg_drive[2*k +: 2] = run ? seg_level(ctx, seg_on[k] && !seg_blank) : LV_GND;
    end

    // Observation helpers for the checks below
    logic [3:0] com_extreme;
    logic       any_upper_mid;
    always_comb begin
        for (int c = 0; c < DEDICATED_COMS; c++)
            com_extreme[c] = (com_drive[2*c +: 2] == 2'd0) || (com_drive[2*c +: 2] == 2'd3);
        com_extreme[3] = quarter_duty && ((shared_drive == 2'd0) || (shared_drive == 2'd3));
        any_upper_mid  = (shared_drive == 2'd2);
        for (int c = 0; c < DEDICATED_COMS; c++)
            any_upper_mid = any_upper_mid || (com_drive[2*c +: 2] == 2'd2);
        for (int k = 0; k < SEG_PINS; k++)
            any_upper_mid = any_upper_mid || (seg_drive[2*k +: 2] == 2'd2);
    end

    // R10: exactly one common at an extreme level while driving
    assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
        !power_save |-> ($countones(com_extreme) == 1));

    // R7: half bias uses only three levels
    assert_no_upper_mid_R7: assert property (@(posedge clk) disable iff (rst)
        !third_bias |-> !any_upper_mid);

    // R9: power save darkens every pin
    assert_dark_R9: assert property (@(posedge clk) disable iff (rst)
        power_save |-> (com_drive == '0 && shared_drive == '0 && seg_drive == '0));

endmodule

// File: tb/tb_lcd_mux_sequencer.sv
module tb_lcd_mux_sequencer;
    localparam int SP  = 4;
    localparam int DIV = 3;

    logic          clk = 1'b0;
    logic          rst, osc_en, duty4, bias3, blank, ps;
    logic [4*SP-1:0] disp;
    logic [5:0]      com_drive;
    logic [1:0]      shared_drive;
    logic [2*SP-1:0] seg_drive;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lcd_mux_sequencer #(.SEG_PINS(SP), .DIV_RATIO(DIV)) dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .disp_bits(disp),
        .quarter_duty(duty4), .third_bias(bias3), .seg_blank(blank),
        .power_save(ps), .com_drive(com_drive), .shared_drive(shared_drive),
        .seg_drive(seg_drive)
    );

    // Bench timing model built from R1, R2 and R9
    int m_cnt, m_slot;
    logic m_neg;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_slot <= 0; m_neg <= 1'b0;
        end else if (osc_en && !ps) begin
            if (m_cnt == DIV - 1) begin
                m_cnt <= 0;
                if (m_slot >= (duty4 ? 3 : 2)) begin
                    m_slot <= 0; m_neg <= ~m_neg;
                end else m_slot <= m_slot + 1;
            end else m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic [1:0] e_com(input int c);
        if (c == m_slot) return m_neg ? 2'd0 : 2'd3;
        return (bias3 && m_neg) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] e_seg(input int k);
        logic on;
        int idx;
        idx = duty4 ? 4*k + m_slot : 3*k + m_slot;
        on  = disp[idx] && !blank;
        if (on) return m_neg ? 2'd3 : 2'd0;
        if (!bias3) return 2'd1;
        return m_neg ? 2'd1 : 2'd2;
    endfunction

    task automatic check_out(input string tag);
        logic [5:0]      ec;
        logic [1:0]      es;
        logic [2*SP-1:0] eg;
        if (rst || ps) begin
            ec = '0; es = '0; eg = '0;
        end else begin
            for (int c = 0; c < 3; c++) ec[2*c +: 2] = e_com(c);
            es = duty4 ? e_com(3) : e_seg(SP);
            for (int k = 0; k < SP; k++) eg[2*k +: 2] = e_seg(k);
        end
        checks++;
        if (com_drive !== ec || shared_drive !== es || seg_drive !== eg) begin
            errors++;
            $display("FAIL %s: com=%h shared=%h seg=%h expected com=%h shared=%h seg=%h",
                     tag, com_drive, shared_drive, seg_drive, ec, es, eg);
        end
    endtask

    task automatic check_extremes(input string tag);
        int n = 0;
        for (int c = 0; c < 3; c++)
            if (com_drive[2*c +: 2] == 2'd0 || com_drive[2*c +: 2] == 2'd3) n++;
        if (duty4 && (shared_drive == 2'd0 || shared_drive == 2'd3)) n++;
        checks++;
        if (n != 1) begin
            errors++;
            $display("FAIL %s: extreme commons=%0d expected 1", tag, n);
        end
    endtask

    task automatic check_no_upper(input string tag);
        int n = 0;
        for (int c = 0; c < 3; c++) if (com_drive[2*c +: 2] == 2'd2) n++;
        for (int k = 0; k < SP; k++) if (seg_drive[2*k +: 2] == 2'd2) n++;
        if (shared_drive == 2'd2) n++;
        checks++;
        if (n != 0) begin
            errors++;
            $display("FAIL %s: code-2 pins=%0d expected 0", tag, n);
        end
    endtask

    task automatic cyc(input int n, input string tag);
        repeat (n) begin
            @(posedge clk); #5;
            check_out(tag);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; osc_en = 1'b1; disp = 16'hA5C3; duty4 = 1'b1;
        bias3 = 1'b1; blank = 1'b0; ps = 1'b0;
        cyc(3, "R1 outputs at ground during reset");
        rst = 1'b0;
        cyc(1, "R1 first slot selects common 1 positive");

        // Sweep every duty and bias combination over several frames
        for (int d = 0; d < 2; d++) begin
            for (int b = 0; b < 2; b++) begin
                duty4 = d[0]; bias3 = b[0]; rst = 1'b1;
                cyc(1, "R1 reset");
                rst = 1'b0;
                for (int n = 0; n < 72; n++) begin
                    osc_en = (n % 5) != 4;
                    if (n % 7 == 0) disp = 16'($urandom);
                    if (d == 1) cyc(1, "R6 R3 R4 R2 quarter-duty scan");
                    else        cyc(1, "R5 R3 R4 R2 third-duty scan");
                    check_extremes("R10 single selected common");
                    if (b == 0) check_no_upper("R7 half bias levels");
                end
            end
        end
        osc_en = 1'b1;

        // Walking single bit through every data position in both duties
        for (int d = 0; d < 2; d++) begin
            duty4 = d[0]; bias3 = 1'b1;
            rst = 1'b1; cyc(1, "R1 reset");
            rst = 1'b0;
            for (int j = 0; j < 4*SP; j++) begin
                disp = 16'(1) << j;
                if (d == 1) cyc(4*DIV, "R6 walking bit mapping");
                else        cyc(3*DIV, "R5 walking bit mapping incl shared segment");
            end
        end

        // Segment blanking in third duty with the shared pin as segment
        duty4 = 1'b0; bias3 = 1'b1; disp = 16'hFFFF; blank = 1'b1;
        cyc(20, "R8 segments forced off");
        blank = 1'b0;
        cyc(3, "R8 segments return");

        // Power save raised on the exact cycle of a slot boundary
        duty4 = 1'b1; bias3 = 1'b0; disp = 16'h3C96;
        rst = 1'b1; cyc(1, "R1 reset"); rst = 1'b0;
        cyc(4, "R2 scan");
        while (m_cnt != DIV - 1) cyc(1, "R2 scan");
        ps = 1'b1;
        cyc(8, "R9 power save dark and frozen");
        ps = 1'b0;
        cyc(14, "R9 resume from frozen slot");

        // Enable low holds the scan
        osc_en = 1'b0;
        cyc(10, "R2 enable low holds slot");
        osc_en = 1'b1;
        cyc(6, "R2 scan resumes");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule